// File: doc/BRIEF.md
# Resynchronizable Divide-by-32 Sync Generator

This block turns a sample clock into a square-wave sync signal at one thirty-second of the clock rate. The signal is high for sixteen clocks and low for sixteen clocks. A 5-bit counter runs freely and sets the phase. Two events reload it from a programmable start value: a rising edge on an asynchronous sync input, and a 0-to-1 change of the output-enable bit. Several devices that share a clock and a common sync input therefore stay phase-aligned.

The output pin is shared with a test data bit. While the enable bit is 0, which is the state after reset, the pin carries the test bit. Once the enable bit is set, the pin carries the divided sync. A sync input that repeats at a multiple of thirty-two clocks reloads the counter with the value it would hold anyway, so the output does not move.

Top module: `sync_divider`

## Requirements
- R1: The sync input passes through two synchronizing registers before edge detection. A 0-to-1 change on the pin, set up before clock edge 1, loads the counter with the start value at edge 3. The output shows the new phase from edge 4.
- R2: Without a reload, the counter advances by one modulo 32 on every clock. A steady high or low sync input, a falling edge, and a change of the start value all leave the phase unchanged.
- R3: With the enable bit at 1, the output is registered one clock behind the counter. It is 1 for counter values 0 to 15 and 0 for values 16 to 31, so each period is 16 clocks high and 16 clocks low.
- R4: A sync input whose rising edges are spaced by a multiple of 32 clocks and aligned to the current phase leaves the output period and phase unchanged.
- R5: A 0-to-1 change of the enable bit loads the start value into the counter. The enable bit is registered once. With the bit set before edge 1, the counter holds the start value after edge 2 and the output shows it from edge 3.
- R6: While the registered enable bit is 0, the output equals the test bit sampled at the previous clock edge. This is the state after reset.
- R7: When no sync-input rising edge occurs, the output keeps cycling with the last loaded phase indefinitely.
- R8: When an enable edge and a sync edge reach the counter in the same cycle, the counter is loaded once with the start value.
- R9: Synchronous active-low reset clears the counter, the output, the enable register and the edge-detect history. A sync input held high across reset is therefore seen as a rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Asynchronous sync input; a rising edge re-phases the divider |
| sync_en | input | 1 | Output enable; 0 selects the test bit, a 0-to-1 change reloads the counter |
| start_val | input | 5 | Counter start value loaded on each reload |
| test_bit | input | 1 | Test data bit driven on the output while disabled |
| sync_out | output | 1 | Registered output: divided sync or test bit |

## Verification
The bench builds the block with its defaults: a 5-bit counter and two synchronizer stages. With a period of 32 clocks, every start value can be swept, and each one is checked over more than a full period against phase arithmetic done in the bench. At this size, long runs with periodic sync, runs with no sync edges, and a coincident enable and sync reload all fit within a few thousand cycles.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the sync divider.
// Assumes: the counter width is a power-of-two divider exponent.
package sdiv_pkg;
    localparam int DEF_CNT_W  = 5;   // divide by 2**5 = 32
    localparam int DEF_STAGES = 2;   // synchronizer depth

    typedef enum logic {
        SEL_TEST = 1'b0,
        SEL_SYNC = 1'b1
    } out_sel_e;
endpackage

// File: rtl/sdiv_synchronizer.sv
`timescale 1ns/1ps
// Module: multi-stage synchronizer for an asynchronous level.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module sdiv_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdiv_rise_detect.sv
`timescale 1ns/1ps
// Module: 0-to-1 transition detector on a registered level.
// Assumes: the input is already synchronous to clk.
module sdiv_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign rise = level & ~prev;

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2
endmodule

// File: rtl/sdiv_counter.sv
`timescale 1ns/1ps
// Module: free-running wrap-around counter with synchronous reload.
// Assumes: load_val is stable in the cycle load is high.
module sdiv_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    // Load the start value or step by one, wrapping at 2**W.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else           cnt <= cnt + 1'b1;
    end

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val)); // R1
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt == W'($past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/sync_divider.sv
`timescale 1ns/1ps
// Module: divide-by-2**CNT_W sync generator, re-phased by the sync input or
// by enabling it, with the output pin shared with a test bit.
// Assumes: sync_en and start_val are synchronous to clk; sync_in is not.
module sync_divider #(
    parameter int CNT_W  = sdiv_pkg::DEF_CNT_W,
    parameter int STAGES = sdiv_pkg::DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             sync_en,
    input  logic [CNT_W-1:0] start_val,
    input  logic             test_bit,
    output logic             sync_out
);
    import sdiv_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HALF_END = CNT_MAX >> 1;

    logic             sync_lvl, sync_rise;
    logic             en_q, en_rise;
    logic             reload;
    logic [CNT_W-1:0] cnt;
    out_sel_e         sel;

    sdiv_synchronizer #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_lvl)
    );

    sdiv_rise_detect u_sync_edge (
        .clk(clk), .rst_n(rst_n), .level(sync_lvl), .rise(sync_rise)
    );

    // Register the enable bit once so its edge and the select are clean.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= sync_en;
    end

    sdiv_rise_detect u_en_edge (
        .clk(clk), .rst_n(rst_n), .level(en_q), .rise(en_rise)
    );

    // Either event reloads the counter; a coincident pair is a single load.
    assign reload = sync_rise | en_rise;

    sdiv_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(reload), .load_val(start_val), .cnt(cnt)
    );

    assign sel = en_q ? SEL_SYNC : SEL_TEST;

    // Register the pin value so the select change cannot glitch it.
    always_ff @(posedge clk) begin
        if (!rst_n)               sync_out <= 1'b0;
        else if (sel == SEL_SYNC) sync_out <= ~cnt[CNT_W-1];
        else                      sync_out <= test_bit;
    end

    AST_TEST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> sync_out == $past(test_bit)); // R6
    AST_HIGH_HALF_END: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cnt == HALF_END) |=> sync_out); // R3
    AST_LOW_HALF_END: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cnt == CNT_MAX) |=> !sync_out); // R3
endmodule

// File: tb/sync_divider_tb.sv
`timescale 1ns/1ps
module sync_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_in;
    logic       sync_en;
    logic [4:0] start_val;
    logic       test_bit;
    logic       sync_out;

    int n_chk  = 0;
    int n_fail = 0;
    int ph     = 0;
    bit done   = 0;

    sync_divider u_dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_en(sync_en),
        .start_val(start_val), .test_bit(test_bit), .sync_out(sync_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic bit phase_level(int p);
        return (p % 32) < 16;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(logic got, logic exp, string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sync_out=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    // One clock, then compare against the phase the bench tracks.
    task automatic expect_phase(string req);
        step();
        check(sync_out, phase_level(ph), req);
        ph = (ph + 1) % 32;
    endtask

    initial begin
        rst_n = 1'b0; sync_in = 1'b0; sync_en = 1'b0;
        start_val = '0; test_bit = 1'b1;
        @(negedge clk);
        repeat (3) step();
        check(sync_out, 1'b0, "R9 reset output");
        rst_n = 1'b1;

        // R6: test bit passes through while disabled
        for (int i = 0; i < 24; i++) begin
            test_bit = ((i * 7 + 3) % 5) < 2;
            step();
            check(sync_out, test_bit, "R6 test passthrough");
        end

        // R5: enable edge reloads the start value
        start_val = 5'd9;
        sync_en = 1'b1;
        step(); step();
        ph = 9;
        repeat (64) expect_phase("R5 enable reload");

        // R1/R2/R3: sweep every start value via a sync edge
        for (int s = 0; s < 32; s++) begin
            start_val = 5'(s);
            sync_in = 1'b1;
            step(); step(); step();
            sync_in = 1'b0;
            start_val = ~5'(s);
            ph = s;
            repeat (8)  expect_phase("R1 sync reload latency");
            repeat (32) expect_phase("R3 half-high half-low");
        end

        // R4: aligned periodic sync input leaves phase undisturbed
        start_val = 5'd7;
        for (int i = 0; i < 164; i++) begin
            sync_in = (i % 32) < 16;
            step();
            if (i == 3) ph = 7;
            if (i >= 3) begin
                check(sync_out, phase_level(ph), "R4 periodic sync");
                ph = (ph + 1) % 32;
            end
        end
        sync_in = 1'b0;

        // R7: no sync edges, the phase persists
        repeat (200) expect_phase("R7 free running");

        // R6 again: disabling returns the pin to the test bit
        sync_en = 1'b0;
        step(); step();
        for (int i = 0; i < 4; i++) begin
            test_bit = i[0];
            step();
            check(sync_out, test_bit, "R6 after disable");
        end

        // R8: enable edge and sync edge reach the counter together
        start_val = 5'd20;
        sync_in = 1'b1;
        step();
        sync_en = 1'b1;
        step(); step();
        ph = 20;
        repeat (40) expect_phase("R8 coincident reload");

        // R9: history cleared, so a high sync input across reset is an edge
        start_val = 5'd15;
        rst_n = 1'b0;
        step(); step();
        check(sync_out, 1'b0, "R9 reset output");
        rst_n = 1'b1;
        step(); step(); step();
        ph = 15;
        repeat (40) expect_phase("R9 edge after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (R1..R9 run): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule